// File: doc/BRIEF.md
# Signed PWM Control Generator

This block converts a signed correction value, written by a processor, into a pulse-width-modulated waveform. The waveform steers a voltage-controlled crystal oscillator through an external filter. Software writes an (n+1)-bit two's-complement control value into a staging register. It then writes a commit bit, and the value moves to the active register at the start of the next PWM period. The width n comes from a configuration input. It sets both the legal signed range and the PWM period of 2^(n+1) clocks. The high time is 2^n plus the signed value, so a value of zero gives 50 % duty.

The most negative code, -2^n, is not a legal setting. If it is committed, it is clamped to -(2^n - 1) and a sticky error flag is raised. A busy output stays high while a committed value waits for its period boundary.

Top module: `sgn_pwm_gen`

## Requirements
- R1: After reset the active value is 0, the effective n is RESET_N (default 4), busy_o is 0 and the error flag is 0, so pwm_o runs with period 2^(RESET_N+1) clocks and high time 2^RESET_N.
- R2: The PWM period is 2^(n+1) clocks, where n is the width in force for that period.
- R3: In each period the high time equals 2^n + v, where v is the active signed value.
- R4: A write to the staging register (wr_addr = 0) changes neither pwm_o nor busy_o.
- R5: A write to the control register (wr_addr = 1) with data bit 0 set commits the staged value. busy_o is 1 from the cycle after the commit until the period boundary where the value takes effect, and the active value never changes inside a period.
- R6: n is taken from cfg_n when the commit is made. A cfg_n of 0 is treated as 1 and a cfg_n above NMAX (default 8) is treated as NMAX. A cfg_n change without a commit has no effect.
- R7: The staged value is read as its low n+1 bits, with the sign at bit n. Staged bits above bit n are ignored.
- R8: Committing the code -2^n makes the active value -(2^n - 1) and sets the error flag, which reads back as control bit 1.
- R9: The error flag is sticky. It clears only when the control register is written with data bit 1 set. If the same write commits the illegal code, setting wins.
- R10: Reads are registered, so rd_data is valid one cycle after rd_addr. Address 0 returns the staging register. Address 1 returns busy at bit 2, error at bit 1, and the commit bit 0 always reads as 0.
- R11: When several commits arrive before one boundary, the last one is the value that takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 staging, 1 control |
| wr_data | input | DW | Write data |
| rd_addr | input | 1 | Read address: 0 staging, 1 control |
| rd_data | output | DW | Registered read data |
| cfg_n | input | NSW | Requested comparison width n |
| pwm_o | output | 1 | PWM output |
| busy_o | output | 1 | Committed value waiting for its period boundary |

## Verification
The bench targets the most negative code. A design that passed this code through would stretch the duty to zero high time, and a design that dropped the flag would leave bit 1 clear. The bench also checks that staged bits above bit n are ignored and that only the last of two quick commits survives. It clamps cfg_n values of 0 and above NMAX, and drives the extremes ±(2^n - 1), where an off-by-one in the compare loses or adds a high cycle. It confirms that a staging write or a cfg_n change without a commit leaves the waveform unchanged, which catches a design that applies values on write.

// File: rtl/sgn_pwm_pkg.sv
package sgn_pwm_pkg;
  typedef enum logic {
    REG_STAGE = 1'b0,
    REG_CTRL  = 1'b1
  } reg_sel_e;

  localparam int CTRL_COMMIT_BIT = 0;
  localparam int CTRL_ERR_BIT    = 1;
  localparam int CTRL_BUSY_BIT   = 2;
endpackage

// File: rtl/sgn_pwm_regs.sv
module sgn_pwm_regs
  import sgn_pwm_pkg::*;
#(
  parameter int DW   = 16,
  parameter int W    = 9,
  parameter int NSW  = 4,
  parameter int NMAX = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic           wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic           rd_addr,
  input  logic [NSW-1:0] cfg_n,
  input  logic           busy_i,
  input  logic           min_code_i,
  output logic [W-1:0]   stage_o,
  output logic [NSW-1:0] n_eff_o,
  output logic           commit_o,
  output logic           err_clr_o,
  output logic           err_o,
  output logic [DW-1:0]  rd_data_o
);
  logic [W-1:0]  stage_q;
  logic          err_q;
  logic [DW-1:0] rd_q;
  logic          ctrl_wr;

  always_comb begin
    ctrl_wr   = wr_en && (wr_addr == REG_CTRL);
    commit_o  = ctrl_wr && wr_data[CTRL_COMMIT_BIT];
    err_clr_o = ctrl_wr && wr_data[CTRL_ERR_BIT];
    if (cfg_n == '0)
      n_eff_o = NSW'(1);
    else if (int'(cfg_n) > NMAX)
      n_eff_o = NSW'(NMAX);
    else
      n_eff_o = cfg_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      err_q   <= 1'b0;
      rd_q    <= '0;
    end else begin
      if (wr_en && (wr_addr == REG_STAGE))
        stage_q <= wr_data[W-1:0];
      if (commit_o && min_code_i)
        err_q <= 1'b1;
      else if (err_clr_o)
        err_q <= 1'b0;
      if (rd_addr == REG_STAGE)
        rd_q <= DW'(stage_q);
      else begin
        rd_q <= '0;
        rd_q[CTRL_ERR_BIT]  <= err_q;
        rd_q[CTRL_BUSY_BIT] <= busy_i;
      end
    end
  end

  assign stage_o   = stage_q;
  assign err_o     = err_q;
  assign rd_data_o = rd_q;
endmodule

// File: rtl/sgn_pwm_conv.sv
module sgn_pwm_conv #(
  parameter int W   = 9,
  parameter int NSW = 4
) (
  input  logic [W-1:0]   raw_i,
  input  logic [NSW-1:0] n_i,
  output logic [W-1:0]   val_o,
  output logic           min_code_o
);
  logic [W-1:0] ext;
  logic [W:0]   pw;
  logic [W-1:0] low_mask;
  logic         sgn;

  assign sgn = raw_i[n_i];

  // sign extension from bit n, one cell per bit position
  for (genvar i = 0; i < W; i++) begin : g_ext
    assign ext[i] = (i <= int'(n_i)) ? raw_i[i] : sgn;
  end

  always_comb begin
    pw         = (W+1)'(1) << n_i;
    low_mask   = pw[W-1:0] - 1'b1;
    min_code_o = sgn && ((raw_i & low_mask) == '0);
    if (min_code_o)
      val_o = (~low_mask) + 1'b1;
    else
      val_o = ext;
  end
endmodule

// File: rtl/sgn_pwm_core.sv
module sgn_pwm_core #(
  parameter int W       = 9,
  parameter int NSW     = 4,
  parameter int RESET_N = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           commit_i,
  input  logic [W-1:0]   val_i,
  input  logic [NSW-1:0] n_i,
  output logic           pwm_o,
  output logic           busy_o,
  output logic           wrap_o,
  output logic [W-1:0]   cnt_o,
  output logic [W-1:0]   act_val_o,
  output logic [NSW-1:0] act_n_o
);
  logic [W-1:0]   cnt_q, last, pend_val_q, act_val_q;
  logic [NSW-1:0] pend_n_q, act_n_q;
  logic           pend_q, pwm_q, wrap;
  logic [W:0]     span, half, hi;

  always_comb begin
    span = (W+1)'(1) << ({1'b0, act_n_q} + 1'b1);
    last = span[W-1:0] - 1'b1;
    half = (W+1)'(1) << act_n_q;
    hi   = half + {act_val_q[W-1], act_val_q};
    wrap = (cnt_q == last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      pwm_q      <= 1'b0;
      pend_q     <= 1'b0;
      pend_val_q <= '0;
      pend_n_q   <= NSW'(RESET_N);
      act_val_q  <= '0;
      act_n_q    <= NSW'(RESET_N);
    end else begin
      pwm_q <= ({1'b0, cnt_q} < hi);
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (wrap && pend_q) begin
        act_val_q <= pend_val_q;
        act_n_q   <= pend_n_q;
      end
      if (commit_i) begin
        pend_q     <= 1'b1;
        pend_val_q <= val_i;
        pend_n_q   <= n_i;
      end else if (wrap) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign pwm_o     = pwm_q;
  assign busy_o    = pend_q;
  assign wrap_o    = wrap;
  assign cnt_o     = cnt_q;
  assign act_val_o = act_val_q;
  assign act_n_o   = act_n_q;
endmodule

// File: rtl/sgn_pwm_gen.sv
module sgn_pwm_gen #(
  parameter int NMAX    = 8,
  parameter int RESET_N = 4,
  parameter int DW      = 16,
  localparam int W      = NMAX + 1,
  localparam int NSW    = $clog2(NMAX + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic           wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic           rd_addr,
  output logic [DW-1:0]  rd_data,
  input  logic [NSW-1:0] cfg_n,
  output logic           pwm_o,
  output logic           busy_o
);
  logic [W-1:0]   stage, conv_val, act_val, cnt;
  logic [NSW-1:0] n_eff, act_n;
  logic           commit, err_clr, err, min_code, wrap;

  sgn_pwm_regs #(.DW(DW), .W(W), .NSW(NSW), .NMAX(NMAX)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .cfg_n(cfg_n), .busy_i(busy_o), .min_code_i(min_code),
    .stage_o(stage), .n_eff_o(n_eff), .commit_o(commit), .err_clr_o(err_clr),
    .err_o(err), .rd_data_o(rd_data)
  );

  sgn_pwm_conv #(.W(W), .NSW(NSW)) u_conv (
    .raw_i(stage), .n_i(n_eff), .val_o(conv_val), .min_code_o(min_code)
  );

  sgn_pwm_core #(.W(W), .NSW(NSW), .RESET_N(RESET_N)) u_core (
    .clk(clk), .rst(rst), .commit_i(commit), .val_i(conv_val), .n_i(n_eff),
    .pwm_o(pwm_o), .busy_o(busy_o), .wrap_o(wrap), .cnt_o(cnt),
    .act_val_o(act_val), .act_n_o(act_n)
  );
endmodule

// File: rtl/sgn_pwm_chk.sv
module sgn_pwm_chk #(
  parameter int W    = 9,
  parameter int NSW  = 4,
  parameter int NMAX = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           commit,
  input logic           err_clr,
  input logic           err,
  input logic           busy,
  input logic           wrap,
  input logic [W-1:0]   cnt,
  input logic [W-1:0]   act_val,
  input logic [NSW-1:0] act_n
);
  logic [W+1:0] half_x, sum_x, span_x;

  always_comb begin
    half_x = (W+2)'(1) << act_n;
    sum_x  = half_x + {{2{act_val[W-1]}}, act_val};
    span_x = (W+2)'(1) << ({1'b0, act_n} + 1'b1);
  end

  // R5: active settings only move at a period boundary
  p_act_stable_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(wrap) |-> ($stable(act_val) && $stable(act_n)));

  p_busy_after_commit_r5: assert property (@(posedge clk) disable iff (rst)
    commit |=> busy);

  p_busy_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && wrap && !commit) |=> !busy);

  // R8: the active high time stays at least one clock
  p_no_min_code_r8: assert property (@(posedge clk) disable iff (rst)
    (sum_x != '0) && !sum_x[W+1]);

  // R9: flag holds unless cleared
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (err && !err_clr) |=> err);

  // R6: active width within the clamped range
  p_n_range_r6: assert property (@(posedge clk) disable iff (rst)
    (act_n != '0) && (int'(act_n) <= NMAX));

  // R2: counter stays inside the period
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    {2'b00, cnt} < span_x);
endmodule

bind sgn_pwm_gen sgn_pwm_chk #(.W(W), .NSW(NSW), .NMAX(NMAX)) u_chk (
  .clk(clk), .rst(rst), .commit(commit), .err_clr(err_clr), .err(err),
  .busy(busy_o), .wrap(wrap), .cnt(cnt), .act_val(act_val), .act_n(act_n)
);

// File: tb/sim_sgn_pwm_gen.sv
module sim_sgn_pwm_gen;
  localparam int NMAX = 8;
  localparam int RN   = 4;
  localparam int DW   = 16;
  localparam int W    = NMAX + 1;
  localparam int NSW  = $clog2(NMAX + 1);

  logic clk = 1'b0;
  logic rst, wr_en, wr_addr, rd_addr, pwm_o, busy_o;
  logic [DW-1:0]  wr_data, rd_data;
  logic [NSW-1:0] cfg_n;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sgn_pwm_gen #(.NMAX(NMAX), .RESET_N(RN), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cfg_n(cfg_n), .pwm_o(pwm_o), .busy_o(busy_o)
  );

  function automatic int eff_n(int c);
    if (c == 0) return 1;
    if (c > NMAX) return NMAX;
    return c;
  endfunction

  // signed value from the low n+1 bits, minimum code clamped
  function automatic int exp_val(int raw, int n);
    int low = raw & ((2 << n) - 1);
    int v = (low >= (1 << n)) ? low - (2 << n) : low;
    if (v == -(1 << n)) v = -((1 << n) - 1);
    return v;
  endfunction

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wr(logic a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic a, output int d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = int'(rd_data);
  endtask

  task automatic measure(output int hi, output int per);
    logic p;
    while (busy_o) @(negedge clk);
    p = pwm_o;
    @(negedge clk);
    while (!(!p && pwm_o)) begin p = pwm_o; @(negedge clk); end
    hi = 0; per = 0;
    do begin
      per++;
      if (pwm_o) hi++;
      p = pwm_o;
      @(negedge clk);
    end while (!(!p && pwm_o));
  endtask

  task automatic commit_check(int cfg, string tag);
    cfg_n = NSW'(cfg);
    wr(1'b1, 1);
    chk(tag, int'(busy_o), 1);
  endtask

  task automatic expect_wave(int n, int v, string tag);
    int hi, per;
    measure(hi, per);
    chk(tag, per, 2 << n);
    chk(tag, hi, (1 << n) + v);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int d, n, v, raw;
    void'($urandom(32'd7741));
    rst = 1'b1; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0; rd_addr = 1'b0; cfg_n = NSW'(3);
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 busy", int'(busy_o), 0);
    rd(1'b1, d); chk("R1 ctrl", d, 0);
    expect_wave(RN, 0, "R1 R2 R3 reset wave");

    // R4 staging write and R6 cfg change without commit
    wr(1'b0, 5);
    cfg_n = NSW'(2);
    chk("R4 busy", int'(busy_o), 0);
    expect_wave(RN, 0, "R4 R6 no commit");
    rd(1'b0, d); chk("R10 stage read", d, 5);

    // directed extremes
    n = 3;
    wr(1'b0, 7); commit_check(n, "R5 busy");
    expect_wave(n, 7, "R3 max");
    wr(1'b0, 9); commit_check(n, "R5 busy");
    expect_wave(n, -7, "R3 min legal");
    rd(1'b1, d); chk("R10 commit reads 0", d & 1, 0);
    chk("R8 no err on legal", (d >> 1) & 1, 0);

    // R8 minimum code clamp and sticky flag
    wr(1'b0, 8); commit_check(n, "R5 busy");
    expect_wave(n, -7, "R8 clamp");
    rd(1'b1, d); chk("R8 err set", (d >> 1) & 1, 1);
    wr(1'b0, 1); commit_check(n, "R5 busy");
    expect_wave(n, 1, "R9 legal after err");
    rd(1'b1, d); chk("R9 err sticky", (d >> 1) & 1, 1);
    wr(1'b1, 2);
    rd(1'b1, d); chk("R9 err cleared", (d >> 1) & 1, 0);
    wr(1'b0, 16); cfg_n = NSW'(4); wr(1'b1, 3);
    rd(1'b1, d); chk("R9 set wins over clear", (d >> 1) & 1, 1);
    expect_wave(4, -15, "R8 clamp n=4");
    wr(1'b1, 2);

    // R6 cfg clamp
    wr(1'b0, 1); commit_check(0, "R5 busy");
    expect_wave(1, 1, "R6 cfg zero");
    wr(1'b0, 200); commit_check(15, "R5 busy");
    expect_wave(NMAX, 200, "R6 cfg above max");

    // R7 upper bits ignored
    wr(1'b0, 'h1F2); commit_check(2, "R5 busy");
    expect_wave(2, exp_val('h1F2, 2), "R7 upper bits");

    // R11 last commit wins
    wr(1'b0, 3); commit_check(5, "R5 busy");
    wr(1'b0, 60); commit_check(5, "R5 busy");
    expect_wave(5, -4, "R11 last wins");

    // random sweep
    for (int k = 0; k < 24; k++) begin
      int c = int'($urandom_range(0, 15));
      n = eff_n(c);
      v = int'($urandom_range(0, (1 << n) - 1));
      if ($urandom_range(0, 1) == 1) v = -v;
      raw = (int'($urandom_range(0, 255)) << (n + 1)) | (v & ((2 << n) - 1));
      wr(1'b0, raw);
      commit_check(c, "R5 busy");
      expect_wave(n, exp_val(raw, n), "R2 R3 R7 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule